// File: doc/BRIEF.md
# Dual Control Pins with Status-Change Interrupt

This block owns a small group of general-purpose digital pins (two by default) that a host controls through a plain read/write register port. In drive mode every pin outputs the level held in its bit of a control register. Setting a release bit in a mode register stops driving the pins so that outside logic can drive them and they act as inputs. Whatever level is present on each pin is passed through a synchronizer and can be read from a status register.

A second mode bit turns one pin (the interrupt pin, index 1 by default) into an active-high interrupt request. While this mode is on, the block compares the synchronized status word with a copy taken at the most recent host read of the status register. Any difference raises the request, and the request stays high until the host reads the status register again. A host can therefore wait for the line instead of polling. The interrupt pin's own input level plays no part in the comparison while it carries the request, which prevents the pin from triggering itself.

Register addresses: 0 holds the control levels (bit i drives pin i). 1 holds the mode register (bit 0 = release, bit 1 = interrupt mode). 2 holds the read-only status word (bit i = synchronized level of pin i). Address 3 is unused. Read data depends only on the address. Only a read strobe at address 2 has a side effect.

Top module: `pinctl_irq`

## Requirements
- R1: After reset, every pin_oe bit and every pin_out bit is 0, the control register reads 0, and the mode register reads 1 (release on, interrupt mode off).
- R2: A write to address 0 stores wr_data[NPINS-1:0] as the control levels. This value reads back at address 0. With release off and interrupt mode off, pin_out equals those levels and every pin_oe bit is 1.
- R3: With mode bit 0 (release) set and mode bit 1 clear, every pin_oe bit is 0.
- R4: Status bit i at address 2 equals pin_in[i] as sampled two clock edges earlier. A change driven between edges appears in rd_data after exactly the second following rising edge.
- R5: With interrupt mode on, a change of any non-interrupt status bit away from the copy taken at the last status read drives pin_out[1] high after the third rising edge following the pin change.
- R6: A status read (rd_en high at address 2) drops the request at that clock edge. The request then stays high until the next such read.
- R7: With interrupt mode on, pin_oe[1] is 1 whatever the release bit is, and control bit 1 has no effect on pin_out[1].
- R8: With interrupt mode on, a change of the interrupt pin's own input (pin_in[1]) raises no request.
- R9: A raised request stays high after the pin that caused it returns to its snapshot value.
- R10: Address 3 reads 0. Writes to addresses 2 and 3 leave the control and mode registers unchanged.
- R11: Clearing interrupt mode drops the request at once and hands pin 1 back to control bit 1 and the release bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effect only at address 2) |
| addr | input | 2 | Register address |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data for addr, combinational |
| pin_in | input | NPINS | Levels sensed on the pins |
| pin_out | output | NPINS | Levels driven onto the pins |
| pin_oe | output | NPINS | Per-pin output enable, 1 = drive |

## Verification
The assertions assume that rst is high at time zero and that the host never raises wr_en and rd_en together. They also assume that after a write to the mode register, the request checks allow for interrupt mode switching off on the next cycle. The bench meets these conditions. It drives each strobe alone and for one cycle only, changes pin_in only at falling edges, and lets every pin change settle through the synchronizer before it reads status. The interrupt sweep runs every pair of start and end pin patterns. Before each pair it reads status, so each pair starts from a known snapshot and has no pending request.

// File: rtl/pinctl_pkg.sv
package pinctl_pkg;

   localparam int unsigned REG_ADDR_W = 2;

   typedef enum logic [REG_ADDR_W-1:0] {
      RA_CTRL = 2'd0,
      RA_MODE = 2'd1,
      RA_STAT = 2'd2,
      RA_NONE = 2'd3
   } reg_addr_e;

   localparam int unsigned MODE_REL_BIT = 0;
   localparam int unsigned MODE_IRQ_BIT = 1;
   localparam int unsigned MODE_W       = 2;

endpackage

// File: rtl/pinctl_sync.sv
module pinctl_sync #(
   parameter int unsigned W      = 2,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk) begin
      if (rst) chain[0] <= '0;
      else     chain[0] <= d;
   end

   for (genvar k = 1; k < STAGES; k++) begin : g_stage
      always_ff @(posedge clk) begin
         if (rst) chain[k] <= '0;
         else     chain[k] <= chain[k-1];
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/pinctl_regfile.sv
module pinctl_regfile
   import pinctl_pkg::*;
#(
   parameter int unsigned NPINS  = 2,
   parameter int unsigned DATA_W = 8
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  wr_en,
   input  logic                  rd_en,
   input  logic [REG_ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0]     wr_data,
   input  logic [NPINS-1:0]      status,
   output logic [DATA_W-1:0]     rd_data,
   output logic [NPINS-1:0]      ctrl_q,
   output logic                  release_q,
   output logic                  irq_en_q,
   output logic                  stat_rd
);

   localparam int unsigned PAD_W = DATA_W - NPINS;
   localparam int unsigned MPAD  = DATA_W - MODE_W;

   reg_addr_e ra;
   assign ra = reg_addr_e'(addr);

   always_ff @(posedge clk) begin
      if (rst) begin
         ctrl_q    <= '0;
         release_q <= 1'b1;
         irq_en_q  <= 1'b0;
      end else if (wr_en) begin
         unique case (ra)
            RA_CTRL: ctrl_q <= wr_data[NPINS-1:0];
            RA_MODE: begin
               release_q <= wr_data[MODE_REL_BIT];
               irq_en_q  <= wr_data[MODE_IRQ_BIT];
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      unique case (ra)
         RA_CTRL: rd_data = {{PAD_W{1'b0}}, ctrl_q};
         RA_MODE: rd_data = {{MPAD{1'b0}}, irq_en_q, release_q};
         RA_STAT: rd_data = {{PAD_W{1'b0}}, status};
         default: rd_data = '0;
      endcase
   end

   assign stat_rd = rd_en && (ra == RA_STAT);

endmodule

// File: rtl/pinctl_change.sv
module pinctl_change #(
   parameter int unsigned NPINS   = 2,
   parameter int unsigned IRQ_PIN = 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [NPINS-1:0] status,
   input  logic             irq_en,
   input  logic             stat_rd,
   output logic             pending
);

   localparam logic [NPINS-1:0] OWN_BIT = NPINS'(1) << IRQ_PIN;

   logic [NPINS-1:0] snap_q;
   logic [NPINS-1:0] cmp_mask;
   logic             differs;

   assign cmp_mask = irq_en ? ~OWN_BIT : '1;
   assign differs  = |((status ^ snap_q) & cmp_mask);

   always_ff @(posedge clk) begin
      if (rst) begin
         snap_q  <= '0;
         pending <= 1'b0;
      end else if (stat_rd) begin
         snap_q  <= status;
         pending <= 1'b0;
      end else begin
         pending <= irq_en && (pending || differs);
      end
   end

endmodule

// File: rtl/pinctl_irq.sv
module pinctl_irq
   import pinctl_pkg::*;
#(
   parameter int unsigned NPINS       = 2,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned IRQ_PIN     = 1
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  wr_en,
   input  logic                  rd_en,
   input  logic [REG_ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0]     wr_data,
   output logic [DATA_W-1:0]     rd_data,
   input  logic [NPINS-1:0]      pin_in,
   output logic [NPINS-1:0]      pin_out,
   output logic [NPINS-1:0]      pin_oe
);

   if (NPINS < 2 || NPINS > DATA_W) begin : g_bad_npins
      $error("pinctl_irq: NPINS must lie in 2..DATA_W");
   end
   if (IRQ_PIN >= NPINS) begin : g_bad_irqpin
      $error("pinctl_irq: IRQ_PIN must be below NPINS");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("pinctl_irq: SYNC_STAGES must be at least 2");
   end
   if (DATA_W < MODE_W) begin : g_bad_dw
      $error("pinctl_irq: DATA_W too narrow for mode register");
   end

   logic [NPINS-1:0] status;
   logic [NPINS-1:0] ctrl_q;
   logic             release_q;
   logic             irq_en_q;
   logic             stat_rd;
   logic             pending;

   pinctl_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (pin_in),
      .q   (status)
   );

   pinctl_regfile #(.NPINS(NPINS), .DATA_W(DATA_W)) u_regs (
      .clk       (clk),
      .rst       (rst),
      .wr_en     (wr_en),
      .rd_en     (rd_en),
      .addr      (addr),
      .wr_data   (wr_data),
      .status    (status),
      .rd_data   (rd_data),
      .ctrl_q    (ctrl_q),
      .release_q (release_q),
      .irq_en_q  (irq_en_q),
      .stat_rd   (stat_rd)
   );

   pinctl_change #(.NPINS(NPINS), .IRQ_PIN(IRQ_PIN)) u_chg (
      .clk     (clk),
      .rst     (rst),
      .status  (status),
      .irq_en  (irq_en_q),
      .stat_rd (stat_rd),
      .pending (pending)
   );

   for (genvar i = 0; i < NPINS; i++) begin : g_pin
      if (i == IRQ_PIN) begin : g_irq
         assign pin_out[i] = irq_en_q ? pending : ctrl_q[i];
         assign pin_oe[i]  = irq_en_q | ~release_q;
      end else begin : g_gpio
         assign pin_out[i] = ctrl_q[i];
         assign pin_oe[i]  = ~release_q;
      end
   end

endmodule

// File: rtl/pinctl_irq_chk.sv
module pinctl_irq_chk #(
   parameter int unsigned NPINS   = 2,
   parameter int unsigned IRQ_PIN = 1
) (
   input logic             clk,
   input logic             rst,
   input logic             rd_en,
   input logic [1:0]       addr,
   input logic [NPINS-1:0] pin_out,
   input logic [NPINS-1:0] pin_oe,
   input logic             release_q,
   input logic             irq_en_q
);

   // R1: first cycle out of reset, nothing is driven
   a_r1_released_after_reset: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (pin_oe == '0));

   // R2: drive mode enables every pin
   a_r2_all_driven: assert property (@(posedge clk) disable iff (rst)
      (!release_q && !irq_en_q) |-> (pin_oe == '1));

   // R3: release mode enables no pin
   a_r3_all_released: assert property (@(posedge clk) disable iff (rst)
      (release_q && !irq_en_q) |-> (pin_oe == '0));

   // R7: interrupt pin is always driven in interrupt mode
   a_r7_irq_pin_driven: assert property (@(posedge clk) disable iff (rst)
      irq_en_q |-> pin_oe[IRQ_PIN]);

   // R6: a status read clears the request
   a_r6_read_clears: assert property (@(posedge clk) disable iff (rst)
      (irq_en_q && rd_en && addr == 2'd2) |=> (!irq_en_q || !pin_out[IRQ_PIN]));

   // R9: a raised request holds until a status read
   a_r9_request_sticky: assert property (@(posedge clk) disable iff (rst)
      (irq_en_q && pin_out[IRQ_PIN] && !(rd_en && addr == 2'd2))
      |=> (!irq_en_q || pin_out[IRQ_PIN]));

endmodule

bind pinctl_irq pinctl_irq_chk #(.NPINS(NPINS), .IRQ_PIN(IRQ_PIN)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .rd_en     (rd_en),
   .addr      (addr),
   .pin_out   (pin_out),
   .pin_oe    (pin_oe),
   .release_q (release_q),
   .irq_en_q  (irq_en_q)
);

// File: tb/sim_pinctl_irq.sv
`timescale 1ns/1ps
module sim_pinctl_irq;

   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          wr_en = 1'b0;
   logic          rd_en = 1'b0;
   logic [1:0]    addr = 2'd0;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] rd_data;
   logic [1:0]    pin_in = 2'b00;
   logic [1:0]    pin_out;
   logic [1:0]    pin_oe;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   pinctl_irq u0 (
      .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wr_data(wr_data), .rd_data(rd_data), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      #1;
   endtask

   task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      #1 d = rd_data;
      @(negedge clk);
      rd_en = 1'b0;
      #1;
   endtask

   initial begin
      #400000;
      if (!done) begin
         miscompares++;
         vectors++;
         $display("FAIL watchdog R1..R11 run hung actual=running expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] d;
      repeat (4) @(posedge clk);
      @(negedge clk) rst = 1'b0;
      #1;
      // R1 reset state
      chk("R1 oe", pin_oe, 2'b00);
      chk("R1 out", pin_out, 2'b00);
      rd(2'd0, d); chk("R1 ctrl", d, 0);
      rd(2'd1, d); chk("R1 mode", d, 1);

      // R2 / R3 sweep of release and control levels
      for (int rel = 0; rel < 2; rel++) begin
         for (int c = 0; c < 4; c++) begin
            wr(2'd1, DW'(rel));
            wr(2'd0, DW'(c));
            chk(rel ? "R3 oe" : "R2 oe", pin_oe, rel ? 2'b00 : 2'b11);
            chk("R2 out", pin_out, c[1:0]);
            rd(2'd0, d); chk("R2 readback", d, c);
         end
      end

      // R4 synchronizer latency sweep
      wr(2'd1, 8'd1);
      wr(2'd0, 8'd0);
      for (int p = 0; p < 4; p++) begin
         for (int prev = 0; prev < 4; prev++) begin
            @(negedge clk); pin_in = prev[1:0]; addr = 2'd2;
            repeat (3) @(posedge clk);
            @(negedge clk); pin_in = p[1:0];
            @(posedge clk); #1 chk("R4 one edge", rd_data, prev);
            @(posedge clk); #1 chk("R4 two edges", rd_data, p);
         end
      end

      // R10 unused address and ignored writes
      wr(2'd0, 8'd2);
      wr(2'd1, 8'd0);
      rd(2'd3, d); chk("R10 unused read", d, 0);
      wr(2'd2, 8'hFF);
      wr(2'd3, 8'hFF);
      rd(2'd0, d); chk("R10 ctrl kept", d, 2);
      rd(2'd1, d); chk("R10 mode kept", d, 0);
      rd(2'd2, d); chk("R10 status kept", d, 3);

      // R7 interrupt pin driven and control bit ignored
      wr(2'd1, 8'd3);
      chk("R7 oe release", pin_oe, 2'b10);
      wr(2'd1, 8'd2);
      chk("R7 oe drive", pin_oe, 2'b11);
      wr(2'd1, 8'd3);
      rd(2'd2, d);
      for (int c = 0; c < 4; c++) begin
         wr(2'd0, DW'(c));
         chk("R7 ctrl ignored", pin_out[1], 1'b0);
         chk("R7 pin0 follows", pin_out[0], c[0]);
      end

      // R5 R6 R8 R9 interrupt sweep over all start/end pin patterns
      wr(2'd0, 8'd0);
      for (int s = 0; s < 4; s++) begin
         for (int e = 0; e < 4; e++) begin
            logic expv;
            expv = (s[0] != e[0]);
            @(negedge clk); pin_in = s[1:0];
            repeat (3) @(posedge clk);
            rd(2'd2, d);
            chk("R6 cleared by read", pin_out[1], 1'b0);
            pin_in = e[1:0];
            repeat (2) @(posedge clk);
            #1 chk("R5 not early", pin_out[1], 1'b0);
            @(posedge clk);
            #1 chk(expv ? "R5 raised" : "R8 no request", pin_out[1], expv);
            repeat (5) @(posedge clk);
            #1 chk("R6 held", pin_out[1], expv);
            @(negedge clk); pin_in = s[1:0];
            repeat (4) @(posedge clk);
            #1 chk("R9 sticky", pin_out[1], expv);
         end
      end

      // R11 leaving interrupt mode
      @(negedge clk); pin_in = 2'b00;
      repeat (3) @(posedge clk);
      rd(2'd2, d);
      @(negedge clk); pin_in = 2'b01;
      repeat (3) @(posedge clk);
      #1 chk("R11 pending before", pin_out[1], 1'b1);
      wr(2'd0, 8'd0);
      wr(2'd1, 8'd1);
      chk("R11 out back to ctrl", pin_out[1], 1'b0);
      chk("R11 oe back to release", pin_oe, 2'b00);
      wr(2'd0, 8'd2);
      chk("R11 ctrl drives pin1", pin_out[1], 1'b1);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule